// File: doc/BRIEF.md
# Universal Pointer Address Decoder

This block turns a 24-bit unified pointer into an access to one of six physical memory spaces. It holds two 24-bit pointers. Each pointer is built from three byte registers. Every access picks one of the pointers and adds a small displacement to it. The block then decodes the sum, without changing the stored pointer, and produces a space code and a native address for that space. Stores into code memory are suppressed. When extended addressing is off, locations that cannot be reached are neither written nor read, and a read of such a location returns FFh.

Separately, the block can advance either pointer by 1 to 4, as a full 24-bit addition. The memories themselves sit outside the block. The block issues a registered read or write strobe with the native address and the store data. On the cycle after the strobe, it returns either the memory's read data or the forced FFh.

Top module: `uptr_xlate`

## Requirements
- R1: An effective address from 00:0000h to 00:FFFFh selects space code 0 (external data), and the native address is the low 16 bits.
- R2: An effective address from 01:0000h to 7E:FFFFh selects space code 1 (high data), and the native address is the low 23 bits.
- R3: 7F:0000h–7F:007Fh selects space code 2 (direct internal). 7F:0080h–7F:00FFh selects space code 3 (indirect internal). In both cases the native address is the low 8 bits.
- R4: 7F:0100h–7F:FFFFh selects space code 4 (extended internal), and the native address is the low 16 bits.
- R5: An address with bit 23 set selects space code 5 (code), and the native address is the low 23 bits.
- R6: The effective address is the selected pointer plus `acc_disp` (0–3), taken modulo 2^24. The stored pointer is left unchanged.
- R7: An advance adds `adv_amt`+1 (so 1–4) to the selected pointer, modulo 2^24. The new value is visible on the pointer outputs one cycle later.
- R8: A write that decodes to space code 5 never raises `acc_we`, and it raises `acc_blk` for one cycle.
- R9: With `ext_en` low, accesses to the following locations raise neither `acc_we` nor `acc_re`: space 1, and space 5 with any of address bits 22:16 set. Such an access raises `acc_blk`, and a read of it returns FFh on `rdata`. All other spaces behave normally.
- R10: Register index 1, 2 or 3 loads byte 0, 1 or 2 of pointer 0. Index 5, 6 or 7 loads byte 0, 1 or 2 of pointer 1. Index 0 and index 4 change nothing. `acc_sel`/`adv_sel` = 0 selects pointer 0, and 1 selects pointer 1.
- R11: Any load request in a cycle suppresses an advance in that cycle. An access in the same cycle as an advance decodes the pointer value from before the advance.
- R12: After reset, both pointers are zero and `acc_vld`, `acc_we`, `acc_re` and `acc_blk` are low.
- R13: Access outputs are registered and appear on the cycle after `acc_en`. In that cycle, `rdata` carries `mem_rdata` for a read that was performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Load one pointer byte |
| ld_reg | input | 3 | Register index to load (1-3, 5-7 used) |
| ld_byte | input | 8 | Byte value to load |
| adv_en | input | 1 | Advance request |
| adv_sel | input | 1 | Pointer to advance |
| adv_amt | input | 2 | Advance amount minus one |
| acc_en | input | 1 | Access request |
| acc_sel | input | 1 | Pointer used by the access |
| acc_disp | input | 2 | Displacement 0-3 |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_wdata | input | 8 | Store data |
| ext_en | input | 1 | Extended addressing enable |
| mem_rdata | input | 8 | Read data from the addressed memory |
| ptr0 | output | 24 | Pointer 0 (bytes from index 3,2,1) |
| ptr1 | output | 24 | Pointer 1 (bytes from index 7,6,5) |
| acc_vld | output | 1 | Access result valid |
| acc_space | output | 3 | Decoded space code |
| acc_addr | output | 23 | Native address |
| acc_we | output | 1 | Write strobe to memory |
| acc_re | output | 1 | Read strobe to memory |
| mem_wdata | output | 8 | Store data to memory |
| acc_blk | output | 1 | One-cycle flag: write suppressed or read forced |
| rdata | output | 8 | Read result (FFh when forced) |

## Verification
An access and an advance can fall in the same cycle, and they may target the same pointer. The access must decode the old value, while the pointer outputs show the advanced value one cycle later. The random mix issues accesses and advances independently in every cycle, with shared or differing selects. A directed case advances a pointer across a space boundary while reading through it. The bench predicts the decode from its own model of the pointer as it stood before the edge. It then compares the pointer outputs against the advanced value, so using the new value for the access and losing the advance both show up.

// File: rtl/uptr_xlate.sv
module uptr_xlate #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic [2:0]    ld_reg,
  input  logic [DW-1:0] ld_byte,
  input  logic          adv_en,
  input  logic          adv_sel,
  input  logic [1:0]    adv_amt,
  input  logic          acc_en,
  input  logic          acc_sel,
  input  logic [1:0]    acc_disp,
  input  logic          acc_wr,
  input  logic [DW-1:0] acc_wdata,
  input  logic          ext_en,
  input  logic [DW-1:0] mem_rdata,
  output logic [23:0]   ptr0,
  output logic [23:0]   ptr1,
  output logic          acc_vld,
  output logic [2:0]    acc_space,
  output logic [22:0]   acc_addr,
  output logic          acc_we,
  output logic          acc_re,
  output logic [DW-1:0] mem_wdata,
  output logic          acc_blk,
  output logic [DW-1:0] rdata
);
  localparam logic [2:0] SP_XD = 3'd0, SP_HD = 3'd1, SP_DIR = 3'd2,
                         SP_IND = 3'd3, SP_EXT = 3'd4, SP_CODE = 3'd5;

  logic [7:0] b0_lo, b0_mid, b0_hi, b1_lo, b1_mid, b1_hi;
  logic       frc;

  assign ptr0 = {b0_hi, b0_mid, b0_lo};
  assign ptr1 = {b1_hi, b1_mid, b1_lo};

  wire [23:0] base = acc_sel ? ptr1 : ptr0;
  wire [23:0] eff  = base + {22'd0, acc_disp};
  wire [23:0] step = {21'd0, adv_amt} + 24'd1;
  wire [23:0] adv0 = ptr0 + step;
  wire [23:0] adv1 = ptr1 + step;

  logic [2:0]  sp;
  logic [22:0] nat;
  logic        reach;

  always_comb begin
    if (eff[23])                  sp = SP_CODE;
    else if (eff[22:16] == 7'h00) sp = SP_XD;
    else if (eff[22:16] != 7'h7F) sp = SP_HD;
    else if (eff[15:8] != 8'h00)  sp = SP_EXT;
    else if (eff[7])              sp = SP_IND;
    else                          sp = SP_DIR;
    case (sp)
      SP_CODE, SP_HD: nat = eff[22:0];
      SP_DIR, SP_IND: nat = {15'd0, eff[7:0]};
      default:        nat = {7'd0, eff[15:0]};
    endcase
    reach = ext_en || (sp != SP_HD && !(sp == SP_CODE && eff[22:16] != 7'h00));
  end

  wire blk_now = !reach || (acc_wr && sp == SP_CODE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {b0_hi, b0_mid, b0_lo} <= '0;
      {b1_hi, b1_mid, b1_lo} <= '0;
    end else if (ld_en) begin
      case (ld_reg)
        3'd1: b0_lo  <= ld_byte;
        3'd2: b0_mid <= ld_byte;
        3'd3: b0_hi  <= ld_byte;
        3'd5: b1_lo  <= ld_byte;
        3'd6: b1_mid <= ld_byte;
        3'd7: b1_hi  <= ld_byte;
        default: ;
      endcase
    end else if (adv_en) begin
      if (adv_sel) {b1_hi, b1_mid, b1_lo} <= adv1;
      else         {b0_hi, b0_mid, b0_lo} <= adv0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_vld <= 1'b0; acc_we <= 1'b0; acc_re <= 1'b0; acc_blk <= 1'b0; frc <= 1'b0;
      acc_space <= '0; acc_addr <= '0; mem_wdata <= '0;
    end else begin
      acc_vld <= acc_en;
      acc_we  <= acc_en && acc_wr && !blk_now;
      acc_re  <= acc_en && !acc_wr && reach;
      acc_blk <= acc_en && blk_now;
      frc     <= acc_en && !acc_wr && !reach;
      if (acc_en) begin
        acc_space <= sp;
        acc_addr  <= nat;
        mem_wdata <= acc_wdata;
      end
    end
  end

  assign rdata = frc ? {DW{1'b1}} : mem_rdata;

  AST_CODE_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_vld && acc_space == SP_CODE |-> !acc_we); // R8
  AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_we && acc_re) && !(acc_blk && acc_we)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_vld |-> !acc_we && !acc_re && !acc_blk); // R13
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_en && !adv_en |=> $stable(ptr0) && $stable(ptr1)); // R6
  AST_ADV_P0: assert property (@(posedge clk) disable iff (!rst_n)
    adv_en && !ld_en && !adv_sel |=> ptr0 == $past(ptr0) + {22'd0, $past(adv_amt)} + 24'd1); // R7
  AST_NOEXT_HD: assert property (@(posedge clk) disable iff (!rst_n)
    acc_vld && !ext_en && $stable(ext_en) && acc_space == SP_HD |-> acc_blk); // R9
  AST_LD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en && (ld_reg == 3'd0 || ld_reg == 3'd4) |=> $stable(ptr0) && $stable(ptr1)); // R11
endmodule

// File: tb/tb_uptr_xlate.sv
module tb_uptr_xlate;
  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic ld_en = 0, adv_en = 0, adv_sel = 0, acc_en = 0, acc_sel = 0, acc_wr = 0, ext_en = 0;
  logic [2:0] ld_reg = 0;
  logic [7:0] ld_byte = 0, acc_wdata = 0;
  logic [1:0] adv_amt = 0, acc_disp = 0;
  logic [7:0] mem_rdata, mem_wdata, rdata;
  logic [23:0] ptr0, ptr1;
  logic acc_vld, acc_we, acc_re, acc_blk;
  logic [2:0] acc_space;
  logic [22:0] acc_addr;

  assign mem_rdata = acc_addr[7:0] ^ 8'hA5;

  uptr_xlate dut (.*);

  int total = 0, bad = 0;
  bit done = 0;
  logic [23:0] m0 = 0, m1 = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // {blk, re, we, space[2:0], addr[22:0]}
  function automatic logic [28:0] model(input logic [23:0] e, input bit ext, input bit wr);
    logic [2:0] s; logic [22:0] a; bit r, b;
    if (e[23])              begin s = 5; a = e[22:0]; end
    else if (e[22:16] == 0) begin s = 0; a = {7'd0, e[15:0]}; end
    else if (e[22:16] != 7'h7F) begin s = 1; a = e[22:0]; end
    else if (e[15:8] != 0)  begin s = 4; a = {7'd0, e[15:0]}; end
    else if (e[7])          begin s = 3; a = {15'd0, e[7:0]}; end
    else                    begin s = 2; a = {15'd0, e[7:0]}; end
    r = ext || !(s == 1 || (s == 5 && e[22:16] != 0));
    b = !r || (wr && s == 5);
    return {b, !wr && r, wr && !b, s, a};
  endfunction

  function automatic string tag_of(input logic [28:0] x, input bit wr);
    if (x[28]) return (wr && x[25:23] == 5) ? "R8" : "R9";
    case (x[25:23])
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2, 3'd3: return "R3";
      3'd4: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic op(input bit le, input logic [2:0] lr, input logic [7:0] lb,
                    input bit ae, input bit as, input logic [1:0] ad, input bit aw,
                    input bit ex, input bit ve, input bit vs, input logic [1:0] va);
    logic [23:0] e; logic [28:0] x; logic [7:0] wd; string t;
    wd = 8'($urandom);
    ld_en = le; ld_reg = lr; ld_byte = lb; acc_en = ae; acc_sel = as; acc_disp = ad;
    acc_wr = aw; ext_en = ex; adv_en = ve; adv_sel = vs; adv_amt = va; acc_wdata = wd;
    e = (as ? m1 : m0) + {22'd0, ad};
    x = model(e, ex, aw);
    @(posedge clk);
    if (le) begin
      case (lr)
        3'd1: m0[7:0] = lb;  3'd2: m0[15:8] = lb;  3'd3: m0[23:16] = lb;
        3'd5: m1[7:0] = lb;  3'd6: m1[15:8] = lb;  3'd7: m1[23:16] = lb;
        default: ;
      endcase
    end else if (ve) begin
      if (vs) m1 = m1 + {22'd0, va} + 24'd1; else m0 = m0 + {22'd0, va} + 24'd1;
    end
    @(negedge clk);
    t = (ve && !le) ? "R7" : (le ? "R10" : (ae && ad != 0 ? "R6" : "R10"));
    if (ve && ae && !le && vs == as) t = "R11";
    if (le && ve) t = "R11";
    chk(ptr0 == m0, t, 32'(ptr0), 32'(m0));
    chk(ptr1 == m1, t, 32'(ptr1), 32'(m1));
    if (ae) begin
      t = tag_of(x, aw);
      chk(acc_vld, "R13", 32'(acc_vld), 1);
      chk(acc_space == x[25:23], t, 32'(acc_space), 32'(x[25:23]));
      chk(acc_addr == x[22:0], t, 32'(acc_addr), 32'(x[22:0]));
      chk({acc_blk, acc_re, acc_we} == x[28:26], t, 32'({acc_blk, acc_re, acc_we}), 32'(x[28:26]));
      if (aw && x[26]) chk(mem_wdata == wd, "R13", 32'(mem_wdata), 32'(wd));
      if (!aw) chk(rdata == (x[28] ? 8'hFF : x[7:0] ^ 8'hA5), t, 32'(rdata),
                   32'(x[28] ? 8'hFF : x[7:0] ^ 8'hA5));
    end else begin
      chk({acc_vld, acc_blk, acc_re, acc_we} == 0, "R13", 32'({acc_vld, acc_blk, acc_re, acc_we}), 0);
    end
  endtask

  task automatic setp(input bit s, input logic [23:0] v);
    op(1, s ? 3'd5 : 3'd1, v[7:0], 0, 0, 0, 0, 0, 0, 0, 0);
    op(1, s ? 3'd6 : 3'd2, v[15:8], 0, 0, 0, 0, 0, 0, 0, 0);
    op(1, s ? 3'd7 : 3'd3, v[23:16], 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  function automatic logic [7:0] pick_hi();
    logic [7:0] t[8] = '{8'h00, 8'h01, 8'h3A, 8'h7E, 8'h7F, 8'h80, 8'hFF, 8'h81};
    return t[$urandom_range(0, 7)];
  endfunction

  function automatic logic [7:0] pick_lo();
    logic [7:0] t[6] = '{8'hFF, 8'hFE, 8'h7F, 8'h7D, 8'h00, 8'h80};
    return ($urandom_range(0, 2) == 0) ? 8'($urandom) : t[$urandom_range(0, 5)];
  endfunction

  initial begin
    #3_000_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk(ptr0 == 0 && ptr1 == 0, "R12", 32'(ptr0 | ptr1), 0);
    chk({acc_vld, acc_we, acc_re, acc_blk} == 0, "R12", 32'({acc_vld, acc_we, acc_re, acc_blk}), 0);

    setp(0, 24'hFFFFFF); op(0, 0, 0, 1, 0, 2'd3, 0, 0, 0, 0, 0);      // R6 wrap to 00:0002
    setp(1, 24'h7F007F); op(0, 0, 0, 1, 1, 2'd1, 0, 0, 0, 0, 0);      // R3 indirect edge
    op(0, 0, 0, 1, 1, 2'd0, 1, 0, 0, 0, 0);                            // R3 direct write
    setp(0, 24'h80FFFF); op(0, 0, 0, 1, 0, 2'd0, 0, 0, 0, 0, 0);      // R5 reachable without ext
    op(0, 0, 0, 1, 0, 2'd1, 0, 0, 0, 0, 0);                            // R9 forced FFh
    op(0, 0, 0, 1, 0, 2'd1, 0, 1, 0, 0, 0);                            // R5 with ext
    op(0, 0, 0, 1, 0, 2'd0, 1, 1, 0, 0, 0);                            // R8 code store
    setp(1, 24'h00FFFF); op(0, 0, 0, 1, 1, 2'd0, 0, 0, 1, 1, 2'd3);   // R11 access old, advance
    op(0, 0, 0, 1, 1, 2'd0, 1, 0, 0, 0, 0);                            // R9 high data store
    op(1, 3'd0, 8'h55, 0, 0, 0, 0, 0, 1, 0, 2'd1);                     // R11 load beats advance
    op(1, 3'd4, 8'h55, 0, 0, 0, 0, 0, 0, 0, 0);                        // R10 index 4 unused
    setp(0, 24'h7F1234); op(0, 0, 0, 1, 0, 2'd2, 1, 0, 0, 0, 0);      // R4 store

    for (int i = 0; i < 3000; i++) begin
      int k = $urandom_range(0, 9);
      if (k == 0)
        op(1, 3'($urandom), ($urandom_range(0, 1) ? pick_hi() : pick_lo()), 1, 1'($urandom),
           2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 2'($urandom));
      else
        op(0, 0, 0, 1'($urandom_range(0, 3) != 0), 1'($urandom), 2'($urandom), 1'($urandom),
           1'($urandom), $urandom_range(0, 2) == 0, 1'($urandom), 2'($urandom));
      if (k == 9) setp(1'($urandom), {pick_hi(), pick_lo(), pick_lo()});
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule